// File: doc/BRIEF.md
# SuperSpeed PHY Power Sequencer

This block is a hardware state machine that owns the control word of a SuperSpeed PHY and performs its bring-up and shutdown with fixed, cycle-exact timing. It takes the place of software that would otherwise write the word step by step and sleep between writes. A start request pulses the PHY reset, restores the word, selects the reference clock source from a strap that says whether an external crystal is present, waits for the reference clock to settle, and then enables the PHY together with the lane-0 power-present signal.

A stop request runs the retention sequence. It drops the PHY enable, then drops the pad reference select, then raises test power-down, one step per cycle. While a sequence runs the block reports busy. A one-cycle done pulse marks the end of each sequence. All waits come from one shared down-counter whose lengths are given in microseconds and turned into cycle counts from the clock frequency parameter.

Top module: `ssphy_pwr_seq`

## Requirements
- R1: After asynchronous reset the control word is 0x0800_0000: test power-down (bit 27) is set and every other bit, including bits 7, 8, 24 and 28, is clear. busy_o and done_o are low.
- R2: A start request seen at a clock edge in the powered-down idle state sets PHY reset (bit 7) and clears test power-down (bit 27) at that edge and raises busy_o. Bit 7 then stays high for exactly RST_CYC cycles, and every other bit keeps its value.
- R3: When the reset pulse ends, the word returns for one cycle to its value from before the start, with bit 27 clear. At the next edge the pad reference select (bit 28) takes the value of xtal_present_i.
- R4: The stabilisation wait that follows the reference select lasts exactly STAB_CYC cycles with the word unchanged.
- R5: At the end of the wait, PHY enable (bit 8) and lane-0 power present (bit 24) are set at the same edge. At that edge done_o rises and busy_o falls.
- R6: A stop request seen in the powered-up idle state clears bit 8 at that edge. The next edge clears bit 28, and the edge after that sets bit 27 and raises done_o. Bit 24 is left unchanged.
- R7: Start and stop requests seen while busy_o is high have no effect. A start while powered up and a stop while powered down also have no effect: the word, busy_o and done_o stay as they were.
- R8: done_o is high for exactly one cycle per completed sequence. busy_o is high from the accepting edge until the completing edge.
- R9: Each wait in cycles is (CLK_HZ / 1,000,000) times its length in microseconds, with a minimum of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request power-up sequence |
| stop_i | input | 1 | Request power-down sequence |
| xtal_present_i | input | 1 | Strap: external crystal reference available |
| ctrl_o | output | 32 | PHY control word (bits 7, 8, 24, 27, 28 driven) |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
Each step has a fixed due cycle, counted from the edge that samples a request. The reset bit appears one edge later and holds RST_CYC cycles. The restored word follows at RST_CYC+1, the reference select at RST_CYC+2, and enable with done at RST_CYC+STAB_CYC+2. The three power-down steps land one, two and three edges after the stop. The driver records the sampling cycle and queues the expected word, busy and done for every later cycle. The monitor compares these at the falling edge of the cycle they are due and flags any expectation that comes due without being checked, so an early or late transition fails on the exact cycle.

// File: rtl/ssphy_seq_pkg.sv
package ssphy_seq_pkg;

  localparam int unsigned CTRL_W       = 32;
  localparam int unsigned BIT_PHY_RST  = 7;
  localparam int unsigned BIT_PHY_EN   = 8;
  localparam int unsigned BIT_LANE_PWR = 24;
  localparam int unsigned BIT_TEST_PD  = 27;
  localparam int unsigned BIT_PAD_REF  = 28;

  typedef enum logic [2:0] {
    ST_DOWN, ST_RST, ST_REFSEL, ST_STAB, ST_UP, ST_PD_PAD, ST_PD_TEST
  } seq_state_e;

  typedef enum logic [2:0] {
    ACT_NONE, ACT_RST_ON, ACT_RST_OFF, ACT_REFSEL,
    ACT_ENABLE, ACT_CLR_EN, ACT_CLR_PAD, ACT_TEST_PD
  } seq_act_e;

  // R9: microseconds to cycles, floored at one cycle
  function automatic longint unsigned us_to_cycles(input longint unsigned clk_hz,
                                                   input longint unsigned us);
    longint unsigned cyc;
    cyc = (clk_hz / 64'd1000000) * us;
    return (cyc == 64'd0) ? 64'd1 : cyc;
  endfunction

  function automatic longint unsigned max_u(input longint unsigned a,
                                            input longint unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ssphy_seq_timer.sv
module ssphy_seq_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  AST_TIMER_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_o && !load_i) |=> zero_o); // R4

endmodule

// File: rtl/ssphy_seq_ctrl.sv
module ssphy_seq_ctrl
  import ssphy_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  seq_act_e          act_i,
  input  logic              xtal_i,
  output logic [CTRL_W-1:0] ctrl_o
);

  localparam logic [CTRL_W-1:0] RESET_WORD = CTRL_W'(1) << BIT_TEST_PD;

  logic [CTRL_W-1:0] word_q;
  logic [CTRL_W-1:0] word_d;
  logic [CTRL_W-1:0] saved_q;

  always_comb begin
    word_d = word_q;
    unique case (act_i)
      ACT_RST_ON: begin
        word_d[BIT_PHY_RST] = 1'b1;
        word_d[BIT_TEST_PD] = 1'b0;
      end
      ACT_RST_OFF: word_d = saved_q;
      ACT_REFSEL:  word_d[BIT_PAD_REF] = xtal_i;
      ACT_ENABLE: begin
        word_d[BIT_PHY_EN]   = 1'b1;
        word_d[BIT_LANE_PWR] = 1'b1;
      end
      ACT_CLR_EN:  word_d[BIT_PHY_EN]  = 1'b0;
      ACT_CLR_PAD: word_d[BIT_PAD_REF] = 1'b0;
      ACT_TEST_PD: word_d[BIT_TEST_PD] = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= RESET_WORD;
      saved_q <= RESET_WORD;
    end else begin
      word_q <= word_d;
      if (act_i == ACT_RST_ON) begin
        saved_q              <= word_q;
        saved_q[BIT_TEST_PD] <= 1'b0;
      end
    end
  end

  assign ctrl_o = word_q;

  AST_PD_AFTER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_q[BIT_TEST_PD]) |-> (!word_q[BIT_PHY_EN] && !word_q[BIT_PAD_REF])); // R6
  AST_RST_LEAVES_PD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_q[BIT_PHY_RST]) |-> !word_q[BIT_TEST_PD]); // R2

endmodule

// File: rtl/ssphy_seq_fsm.sv
module ssphy_seq_fsm
  import ssphy_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start_i,
  input  logic     stop_i,
  input  logic     tmr_zero_i,
  output seq_act_e act_o,
  output logic     tmr_load_o,
  output logic     tmr_sel_stab_o,
  output logic     busy_o,
  output logic     done_o
);

  seq_state_e state_q, state_d;
  logic       done_d;

  always_comb begin
    state_d        = state_q;
    act_o          = ACT_NONE;
    tmr_load_o     = 1'b0;
    tmr_sel_stab_o = 1'b0;
    done_d         = 1'b0;
    unique case (state_q)
      ST_DOWN: if (start_i) begin
        act_o      = ACT_RST_ON;
        tmr_load_o = 1'b1;
        state_d    = ST_RST;
      end
      ST_RST: if (tmr_zero_i) begin
        act_o   = ACT_RST_OFF;
        state_d = ST_REFSEL;
      end
      ST_REFSEL: begin
        act_o          = ACT_REFSEL;
        tmr_load_o     = 1'b1;
        tmr_sel_stab_o = 1'b1;
        state_d        = ST_STAB;
      end
      ST_STAB: if (tmr_zero_i) begin
        act_o   = ACT_ENABLE;
        done_d  = 1'b1;
        state_d = ST_UP;
      end
      ST_UP: if (stop_i) begin
        act_o   = ACT_CLR_EN;
        state_d = ST_PD_PAD;
      end
      ST_PD_PAD: begin
        act_o   = ACT_CLR_PAD;
        state_d = ST_PD_TEST;
      end
      ST_PD_TEST: begin
        act_o   = ACT_TEST_PD;
        done_d  = 1'b1;
        state_d = ST_DOWN;
      end
      default: state_d = ST_DOWN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_DOWN;
      done_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= done_d;
    end
  end

  assign busy_o = (state_q != ST_DOWN) && (state_q != ST_UP);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8
  AST_UP_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_UP && start_i && !stop_i) |=> (state_q == ST_UP)); // R7
  AST_DOWN_IGNORES_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DOWN && stop_i && !start_i) |=> (state_q == ST_DOWN)); // R7

endmodule

// File: rtl/ssphy_pwr_seq.sv
module ssphy_pwr_seq
  import ssphy_seq_pkg::*;
#(
  parameter longint unsigned CLK_HZ  = 125000000,
  parameter longint unsigned RST_US  = 2000,
  parameter longint unsigned STAB_US = 30000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        stop_i,
  input  logic        xtal_present_i,
  output logic [31:0] ctrl_o,
  output logic        busy_o,
  output logic        done_o
);

  localparam longint unsigned RST_CYC  = us_to_cycles(CLK_HZ, RST_US);
  localparam longint unsigned STAB_CYC = us_to_cycles(CLK_HZ, STAB_US);
  localparam longint unsigned CNT_MAX  = max_u(RST_CYC, STAB_CYC);
  localparam int unsigned     TW       = (CNT_MAX < 2) ? 1 : $clog2(CNT_MAX);

  seq_act_e       seq_act;
  logic           tmr_load;
  logic           tmr_sel_stab;
  logic           tmr_zero;
  logic [TW-1:0]  tmr_val;

  assign tmr_val = tmr_sel_stab ? TW'(STAB_CYC - 1) : TW'(RST_CYC - 1);

  ssphy_seq_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .stop_i         (stop_i),
    .tmr_zero_i     (tmr_zero),
    .act_o          (seq_act),
    .tmr_load_o     (tmr_load),
    .tmr_sel_stab_o (tmr_sel_stab),
    .busy_o         (busy_o),
    .done_o         (done_o)
  );

  ssphy_seq_timer #(.W(TW)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  ssphy_seq_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .act_i  (seq_act),
    .xtal_i (xtal_present_i),
    .ctrl_o (ctrl_o)
  );

  AST_ENABLE_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_o[BIT_PHY_EN]) |-> (ctrl_o[BIT_LANE_PWR] && done_o && !busy_o)); // R5
  AST_RESET_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_o[BIT_PHY_RST] |-> busy_o); // R2

endmodule

// File: tb/tb_ssphy_pwr_seq.sv
module tb_ssphy_pwr_seq;

  localparam int CLK_PERIOD = 10;
  localparam longint unsigned T_CLK_HZ  = 2000000;
  localparam longint unsigned T_RST_US  = 3;
  localparam longint unsigned T_STAB_US = 5;
  // R9: cycles restated as (Hz * us) / 1e6
  localparam int RC = int'((T_CLK_HZ * T_RST_US) / 1000000);
  localparam int SC = int'((T_CLK_HZ * T_STAB_US) / 1000000);

  localparam logic [31:0] B_RST  = 32'h0000_0080;
  localparam logic [31:0] B_EN   = 32'h0000_0100;
  localparam logic [31:0] B_LANE = 32'h0100_0000;
  localparam logic [31:0] B_TPD  = 32'h0800_0000;
  localparam logic [31:0] B_PAD  = 32'h1000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        stop_i = 1'b0;
  logic        xtal_present_i = 1'b0;
  logic [31:0] ctrl_o;
  logic        busy_o;
  logic        done_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  ssphy_pwr_seq #(.CLK_HZ(T_CLK_HZ), .RST_US(T_RST_US), .STAB_US(T_STAB_US)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .xtal_present_i(xtal_present_i), .ctrl_o(ctrl_o), .busy_o(busy_o), .done_o(done_o)
  );

  typedef struct {
    int          cyc;
    logic [31:0] word;
    logic        busy;
    logic        done;
    string       req;
  } exp_t;

  exp_t        q[$];
  int          cyc = 0;
  int          n_checks = 0;
  int          n_fail = 0;
  bit          finished = 1'b0;
  logic [31:0] w_model = B_TPD;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(input int c, input logic [31:0] w, input logic b,
                      input logic d, input string r);
    exp_t e;
    e.cyc = c; e.word = w; e.busy = b; e.done = d; e.req = r;
    q.push_back(e);
  endtask

  // monitor: compare each expectation at the falling edge of its cycle
  always @(negedge clk) begin
    if (rst_n) begin
      while (q.size() > 0 && q[0].cyc <= cyc) begin
        exp_t e;
        e = q.pop_front();
        n_checks++;
        if (e.cyc < cyc) begin
          n_fail++;
          $display("FAIL %s: expectation for cycle %0d missed (now %0d)", e.req, e.cyc, cyc);
        end else if (ctrl_o !== e.word || busy_o !== e.busy || done_o !== e.done) begin
          n_fail++;
          $display("FAIL %s: cycle %0d ctrl=%h busy=%b done=%b expected ctrl=%h busy=%b done=%b",
                   e.req, cyc, ctrl_o, busy_o, done_o, e.word, e.busy, e.done);
        end
      end
    end
  end

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // power-up: optional stray requests while busy (R7)
  task automatic run_start(input logic xt, input bit stray);
    int c;
    logic [31:0] base, ws, we;
    @(negedge clk);
    c = cyc;
    start_i = 1'b1;
    xtal_present_i = xt;
    base = w_model & ~B_TPD;
    for (int k = 1; k <= RC; k++) push(c + k, base | B_RST, 1'b1, 1'b0, "R2");
    push(c + RC + 1, base, 1'b1, 1'b0, "R3");
    ws = xt ? (base | B_PAD) : (base & ~B_PAD);
    for (int j = 1; j <= SC; j++) push(c + RC + 1 + j, ws, 1'b1, 1'b0, "R4");
    we = ws | B_EN | B_LANE;
    push(c + RC + SC + 2, we, 1'b0, 1'b1, "R5");
    push(c + RC + SC + 3, we, 1'b0, 1'b0, "R8");
    w_model = we;
    @(negedge clk);
    start_i = 1'b0;
    if (stray) begin
      @(negedge clk); stop_i = 1'b1;
      @(negedge clk); stop_i = 1'b0; start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      wait_until(c + RC + 4);
      stop_i = 1'b1; start_i = 1'b1;
      @(negedge clk); stop_i = 1'b0; start_i = 1'b0;
    end
    wait_until(c + RC + SC + 4);
  endtask

  // power-down (R6), optional stray start during it (R7)
  task automatic run_stop(input bit stray);
    int c;
    logic [31:0] w1, w2, w3;
    @(negedge clk);
    c = cyc;
    stop_i = 1'b1;
    w1 = w_model & ~B_EN;
    w2 = w1 & ~B_PAD;
    w3 = w2 | B_TPD;
    push(c + 1, w1, 1'b1, 1'b0, "R6");
    push(c + 2, w2, 1'b1, 1'b0, "R6");
    push(c + 3, w3, 1'b0, 1'b1, "R6");
    push(c + 4, w3, 1'b0, 1'b0, "R8");
    w_model = w3;
    @(negedge clk);
    stop_i = 1'b0;
    if (stray) start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_until(c + 5);
  endtask

  // request that must be ignored in the current idle state (R7)
  task automatic run_ignored(input bit is_start);
    int c;
    @(negedge clk);
    c = cyc;
    if (is_start) start_i = 1'b1; else stop_i = 1'b1;
    for (int k = 1; k <= 3; k++) push(c + k, w_model, 1'b0, 1'b0, "R7");
    @(negedge clk);
    start_i = 1'b0; stop_i = 1'b0;
    wait_until(c + 4);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    push(cyc + 1, B_TPD, 1'b0, 1'b0, "R1");
    push(cyc + 2, B_TPD, 1'b0, 1'b0, "R1");
    wait_until(cyc + 3);
    run_start(1'b1, 1'b0);   // crystal present
    run_ignored(1'b1);       // start while up
    run_stop(1'b1);          // stray start during power-down
    run_ignored(1'b0);       // stop while down
    run_start(1'b0, 1'b1);   // no crystal, stray requests while busy
    run_stop(1'b0);
    run_start(1'b1, 1'b0);   // lane bit already set from before
    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL R8: %0d expectations left unchecked, expected 0", q.size());
    end
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion before 5000 cycles");
      finish_run();
    end
  end

endmodule